// File: doc/BRIEF.md
# CAN Transmit Pin Test Multiplexer

This block decides what drives the transmit pin of a CAN controller during production or self test. A control register holds a test-enable bit. While that bit is set, a 2-bit select field in a separate test register can be written. The field picks one of four sources for the pin: the protocol engine's serial data, its sample-point strobe, a constant dominant level or a constant recessive level. The register also returns the live level of the receive pin, so the physical layer can be checked from software.

The registers run on the register clock. The pin mux, the serial data and the sample-point strobe run on the kernel clock. The select code reaches the kernel domain through a multi-flop synchronizer. After that synchronizer, a stability filter takes a new code only when it has been seen on two kernel edges in a row. A code that is in flight therefore never reaches the mux. The receive level goes back to the register domain through its own synchronizer.

The block moves no data stream, so it has no valid/ready interface. Every pin is a plain level or a single-cycle write strobe, and no write is ever refused or back-pressured.

Top module: `can_txpin_testmux`

## Requirements
- R1: While reset is held, the test-enable readback is 0, the select readback is 00 and the transmit pin follows the serial data input.
- R2: A select write only takes effect when the test-enable bit already held 1 before that clock edge. A write made while the bit is 0 leaves the select readback and the pin unchanged. This includes a write in the same cycle that sets the bit.
- R3: Writing 0 to the test-enable bit forces the select field to 00 and brings the pin back to serial data. If a select write lands in the same cycle, the clear wins.
- R4: With the applied code 00, the transmit pin equals the serial data input.
- R5: With the applied code 01, the transmit pin equals the sample-point input.
- R6: With the applied code 10 the pin is driven 0 (dominant). With code 11 the pin is driven 1 (recessive).
- R7: With two synchronizer stages and both clocks on the same edges, a select value stored at register edge E0 first drives the pin after kernel edge E0+4. Before that edge the previous function stays in force.
- R8: A select value held in the register for only one cycle is never applied to the pin. Only codes seen on two consecutive kernel edges after the synchronizer are applied.
- R9: The receive readback shows the receive pin level sampled at register edge k, starting after register edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_clk | input | 1 | Register-domain clock |
| reg_rst_n | input | 1 | Register-domain asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_test_en | input | 1 | Test-enable value written by ctl_wr |
| tst_wr | input | 1 | Write strobe for the test register select field |
| tst_sel | input | 2 | Select code: 00 serial, 01 sample point, 10 dominant, 11 recessive |
| test_en_o | output | 1 | Current test-enable bit |
| tst_sel_o | output | 2 | Current select field readback |
| rx_level_o | output | 1 | Synchronized receive pin level |
| ker_clk | input | 1 | Kernel-domain clock |
| ker_rst_n | input | 1 | Kernel-domain asynchronous reset, active low |
| ser_tx_i | input | 1 | Serial data from the protocol engine |
| smp_pt_i | input | 1 | Sample-point strobe from the bit timing logic |
| can_rx_i | input | 1 | Receive pin level |
| can_tx_o | output | 1 | Transmit pin |

## Verification
The bench builds the block with the default of two synchronizer stages. It drives both clock domains from a single clock, so every crossing has an exact, countable latency. That makes the four-edge select path of R7 and the one-edge receive path of R9 checkable on every cycle against a behavioural model. Back-to-back select writes leave a code in the register for a single cycle, which exercises the stability filter. Same-cycle enable and select writes, and same-cycle clear and select writes, exercise the ordering rules of R2 and R3.

// File: rtl/tpm_pkg.sv
`timescale 1ns/1ps
package tpm_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    TXF_SERIAL    = 2'b00,
    TXF_SAMPLE    = 2'b01,
    TXF_DOMINANT  = 2'b10,
    TXF_RECESSIVE = 2'b11
  } txfn_e;
endpackage

// File: rtl/tpm_regs.sv
`timescale 1ns/1ps
module tpm_regs
  import tpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_din,
  input  logic             tst_wr,
  input  logic [SEL_W-1:0] tst_din,
  output logic             en_q,
  output txfn_e            sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= TXF_SERIAL;
    end else begin
      if (ctl_wr) en_q <= ctl_din;
      if (ctl_wr && !ctl_din) sel_q <= TXF_SERIAL;
      else if (tst_wr && en_q) sel_q <= txfn_e'(tst_din);
    end
  end

  // R2: select cannot move while the test-enable bit is clear
  assert_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(sel_q));

  // R3: clearing test enable returns the field to serial data
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_din) |=> (sel_q == TXF_SERIAL && !en_q));
endmodule

// File: rtl/tpm_sync.sv
`timescale 1ns/1ps
module tpm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st[g] <= '0;
      else if (g == 0)  st[g] <= d;
      else              st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tpm_sel_filter.sv
`timescale 1ns/1ps
module tpm_sel_filter
  import tpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] din,
  output txfn_e            sel_k
);
  logic [SEL_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sel_k  <= TXF_SERIAL;
    end else begin
      prev_q <= din;
      if (din == prev_q) sel_k <= txfn_e'(din);
    end
  end

  // R8: a new code is applied only after two matching samples
  assert_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_k != $past(sel_k)) |-> ($past(din) == $past(din, 2)));

  // R7: the applied code is the one the synchronizer delivered
  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_k != $past(sel_k)) |-> (sel_k == txfn_e'($past(din))));
endmodule

// File: rtl/tpm_txmux.sv
`timescale 1ns/1ps
module tpm_txmux
  import tpm_pkg::*;
(
  input  txfn_e sel,
  input  logic  ser,
  input  logic  smp,
  output logic  tx
);
  always_comb begin
    unique case (sel)
      TXF_SERIAL:    tx = ser;
      TXF_SAMPLE:    tx = smp;
      TXF_DOMINANT:  tx = 1'b0;
      TXF_RECESSIVE: tx = 1'b1;
      default:       tx = ser;
    endcase
  end
endmodule

// File: rtl/can_txpin_testmux.sv
`timescale 1ns/1ps
module can_txpin_testmux
  import tpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             reg_clk,
  input  logic             reg_rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_test_en,
  input  logic             tst_wr,
  input  logic [SEL_W-1:0] tst_sel,
  output logic             test_en_o,
  output logic [SEL_W-1:0] tst_sel_o,
  output logic             rx_level_o,
  input  logic             ker_clk,
  input  logic             ker_rst_n,
  input  logic             ser_tx_i,
  input  logic             smp_pt_i,
  input  logic             can_rx_i,
  output logic             can_tx_o
);
  txfn_e            sel_r;
  logic [SEL_W-1:0] sel_sy;
  txfn_e            sel_k;

  tpm_regs u_regs (
    .clk    (reg_clk),
    .rst_n  (reg_rst_n),
    .ctl_wr (ctl_wr),
    .ctl_din(ctl_test_en),
    .tst_wr (tst_wr),
    .tst_din(tst_sel),
    .en_q   (test_en_o),
    .sel_q  (sel_r)
  );
  assign tst_sel_o = sel_r;

  tpm_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sel_sync (
    .clk  (ker_clk),
    .rst_n(ker_rst_n),
    .d    (sel_r),
    .q    (sel_sy)
  );

  tpm_sel_filter u_filt (
    .clk  (ker_clk),
    .rst_n(ker_rst_n),
    .din  (sel_sy),
    .sel_k(sel_k)
  );

  tpm_txmux u_mux (
    .sel(sel_k),
    .ser(ser_tx_i),
    .smp(smp_pt_i),
    .tx (can_tx_o)
  );

  tpm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rx_sync (
    .clk  (reg_clk),
    .rst_n(reg_rst_n),
    .d    (can_rx_i),
    .q    (rx_level_o)
  );
endmodule

// File: tb/tb_can_txpin_testmux.sv
`timescale 1ns/1ps
module tb_can_txpin_testmux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_d = 1'b0, tst_wr = 1'b0;
  logic [1:0] tst_d = 2'b00;
  logic test_en, rx_rd, ser = 1'b0, smp = 1'b0, rx = 1'b0, tx;
  logic [1:0] sel_rd;
  logic rnd_on = 1'b1, dir_ser = 1'b0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  can_txpin_testmux dut (
    .reg_clk(clk), .reg_rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_test_en(ctl_d),
    .tst_wr(tst_wr), .tst_sel(tst_d), .test_en_o(test_en), .tst_sel_o(sel_rd),
    .rx_level_o(rx_rd), .ker_clk(clk), .ker_rst_n(rst_n), .ser_tx_i(ser),
    .smp_pt_i(smp), .can_rx_i(rx), .can_tx_o(tx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // stimulus on free-running inputs, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    rx  <= 1'($urandom);
    smp <= 1'($urandom);
    ser <= rnd_on ? 1'($urandom) : dir_ser;
  end

  // behavioural reference model
  logic       m_en, m_old_en;
  logic [1:0] m_sel, m_selk;
  logic [1:0] hist [4];
  logic       rx_s1, m_rx;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_selk = 0; rx_s1 = 0; m_rx = 0;
      for (int i = 0; i < 4; i++) hist[i] = 0;
    end else begin
      if (hist[2] == hist[3]) m_selk = hist[2];
      m_old_en = m_en;
      if (tst_wr && m_old_en) m_sel = tst_d;
      if (ctl_wr) begin
        m_en = ctl_d;
        if (!ctl_d) m_sel = 0;
      end
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = m_sel;
      m_rx  = rx_s1;
      rx_s1 = rx;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_tx;
      string tg;
      case (m_selk)
        2'b00: begin exp_tx = ser;  tg = "R4"; end
        2'b01: begin exp_tx = smp;  tg = "R5"; end
        2'b10: begin exp_tx = 1'b0; tg = "R6"; end
        default: begin exp_tx = 1'b1; tg = "R6"; end
      endcase
      check(tx == exp_tx, tg, tx, exp_tx);
      check(sel_rd == m_sel, "R2/R3 select readback", sel_rd, m_sel);
      check(test_en == m_en, "R2/R3 enable readback", test_en, m_en);
      check(rx_rd == m_rx, "R9", rx_rd, m_rx);
    end
  end

  task automatic wr_ctl(input logic v);
    @(posedge clk); #1 ctl_wr = 1; ctl_d = v;
    @(posedge clk); #1 ctl_wr = 0;
  endtask

  task automatic wr_sel(input logic [1:0] s);
    @(posedge clk); #1 tst_wr = 1; tst_d = s;
    @(posedge clk); #1 tst_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    check(test_en == 0, "R1 enable", test_en, 0);
    check(sel_rd == 0, "R1 select", sel_rd, 0);
    check(tx == ser, "R1 pin", tx, ser);
    @(posedge clk); #1 rst_n = 1;
    idle(4);

    // R2: write while disabled, then simultaneous enable + write
    wr_sel(2'b10); idle(6);
    @(negedge clk); check(sel_rd == 0, "R2 locked write", sel_rd, 0);
    @(posedge clk); #1 ctl_wr = 1; ctl_d = 1; tst_wr = 1; tst_d = 2'b11;
    @(posedge clk); #1 ctl_wr = 0; tst_wr = 0;
    idle(6);
    @(negedge clk); check(sel_rd == 0, "R2 same-cycle enable", sel_rd, 0);

    // walk all codes
    wr_sel(2'b01); idle(10);
    wr_sel(2'b10); idle(10);
    wr_sel(2'b11); idle(10);
    wr_sel(2'b00); idle(10);

    // R7: exact latency, serial held at 1
    dir_ser = 1; rnd_on = 0; idle(3);
    @(posedge clk); #1 tst_wr = 1; tst_d = 2'b10;
    @(posedge clk); #1 tst_wr = 0;
    for (int i = 1; i <= 4; i++) begin
      @(posedge clk); @(negedge clk);
      check(tx == ((i < 4) ? 1'b1 : 1'b0), "R7 latency", tx, (i < 4) ? 1 : 0);
    end

    // R8: code 11 held one cycle only, serial held at 0
    dir_ser = 0; idle(3);
    @(posedge clk); #1 tst_wr = 1; tst_d = 2'b11;
    @(posedge clk); #1 tst_d = 2'b00;
    @(posedge clk); #1 tst_wr = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); check(tx == 0, "R8 transient code", tx, 0);
    end
    rnd_on = 1;

    // R3: clear with same-cycle select write
    wr_sel(2'b11); idle(8);
    @(posedge clk); #1 ctl_wr = 1; ctl_d = 0; tst_wr = 1; tst_d = 2'b01;
    @(posedge clk); #1 ctl_wr = 0; tst_wr = 0;
    @(negedge clk); check(sel_rd == 0, "R3 clear wins", sel_rd, 0);
    idle(8);
    @(negedge clk); check(tx == ser, "R3 back to serial", tx, ser);

    // re-enable, then clear on its own
    wr_ctl(1); wr_sel(2'b01); idle(8);
    wr_ctl(0); idle(8);
    @(negedge clk); check(sel_rd == 0 && test_en == 0, "R3 plain clear", sel_rd, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule